// File: doc/BRIEF.md
# DSI Clock Lane High-Speed Sequencer

This block sequences the continuous clock lane of a DSI transmit PHY. It runs in the lane byte-clock domain, where one period equals eight HS bit times. It drives the lane's low-power and high-speed driver enables. When it is asked for high-speed clocking, it leaves the LP stop state through a fixed series of timed phases: prepare (both drivers off), HS-zero, and the clock pre-time. It then tells the data lanes that they may begin. When the request is withdrawn, it waits for the data lanes to go idle, runs the clock post-time and the trail, and returns the lane to LP stop.

Every duration is a byte-clock count. Four 8-bit durations are packed into one timing word: prepare in bits 31:24, zero in 23:16, post in 15:8 and trail in 7:0. The pre-time sits in bits 7:0 of a second word, whose upper bits are ignored. A field value n holds its phase for n cycles, and a value of 0 holds it for one cycle.

The lane cannot leave power-down until an internal bias-ready flag is set. That flag is set a programmable number of cycles after power-down is released. A 4-bit status vector {bias_ready, stop, ulps, hs_active} is exported for a status register.

Top module: `dsi_clklane_seq`

## Requirements
- R1: During reset, and while power-down is high, tx_lp_en, tx_hs_en and data_ready are low and the status vector is 4'b0000.
- R2: Power-down is first sampled low at some clock edge. bias_ready (status bit 3) rises at the max(W,1)-th such edge, where W is the power-up wait count. The lane stays in power-down (tx_lp_en low, stop bit low) until the following edge.
- R3: In stop state, tx_lp_en is 1, tx_hs_en is 0, data_ready is 0 and the status vector is 4'b1100. tx_lp_en and tx_hs_en are never high together, and the ulps bit (status bit 1) is always 0.
- R4: A request seen in stop state starts prepare. Prepare lasts max(prepare,1) cycles with both tx_lp_en and tx_hs_en low.
- R5: After prepare, tx_hs_en is high while data_ready and hs_active (status bit 0) are low. This lasts max(zero,1)+max(pre,1) cycles, so data_ready cannot rise before the pre-time has elapsed.
- R6: After the pre-time, data_ready, tx_hs_en and hs_active are high. They stay high while the request is high or while data_idle is low.
- R7: When the request is low and data_idle is high in HS state, data_ready drops at the next edge. tx_hs_en and hs_active stay high for max(post,1) cycles.
- R8: After post, trail keeps tx_hs_en high with hs_active low for max(trail,1) cycles. The lane then returns to stop state.
- R9: If the request drops during entry, the entry still completes. data_ready is then high for exactly one cycle before the exit begins.
- R10: Power-down high at any edge forces the next cycle to the R1 outputs and clears bias_ready, from any phase.
- R11: A request raised during post or trail does not shorten or change the exit. A new entry starts from stop state after one stop cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane byte clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_down_i | input | 1 | Lane power-down |
| hs_req_i | input | 1 | Request for high-speed clocking |
| data_idle_i | input | 1 | All data lanes have finished HS transmission |
| clk_tim_i | input | 4*DUR_W | Packed prepare/zero/post/trail durations |
| clk_pre_tim_i | input | 4*DUR_W | Pre-time in low DUR_W bits, rest ignored |
| pwrup_wait_i | input | PWRUP_W | Bias power-up wait count |
| tx_lp_en_o | output | 1 | LP driver enable |
| tx_hs_en_o | output | 1 | HS driver enable |
| data_ready_o | output | 1 | Data lanes may transmit |
| lane_state_o | output | 4 | {bias_ready, stop, ulps, hs_active} |

## Verification
Full enter/exit cycles are run with distinct, non-zero values in every field. Because the fields differ, a swapped field position or an off-by-one count shows up in the measured phase length. An all-zero word checks the one-cycle minimum, and a varied pre-time separates the pre phase from the zero phase. Four further cases are driven: a request withdrawn during prepare, a held-low data-idle flag, a re-request during exit, and power-down asserted in HS state. Together they tell apart the exit condition, completion of the entry, the exit ordering and the abort path.

// File: rtl/clklane_pkg.sv
package clklane_pkg;

  typedef enum logic [2:0] {
    PH_OFF,
    PH_STOP,
    PH_PREP,
    PH_ZERO,
    PH_PRE,
    PH_HS,
    PH_POST,
    PH_TRAIL
  } phase_e;

  typedef struct packed {
    logic lp_en;
    logic hs_en;
    logic ready;
    logic stop;
    logic hs_act;
  } lane_out_t;

  function automatic lane_out_t phase_outs(phase_e ph);
    lane_out_t o;
    o = '0;
    case (ph)
      PH_STOP:  begin o.lp_en = 1'b1; o.stop = 1'b1; end
      PH_ZERO,
      PH_PRE,
      PH_TRAIL: o.hs_en = 1'b1;
      PH_HS:    begin o.hs_en = 1'b1; o.ready = 1'b1; o.hs_act = 1'b1; end
      PH_POST:  begin o.hs_en = 1'b1; o.hs_act = 1'b1; end
      default:  o = '0;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/clklane_bias_timer.sv
module clklane_bias_timer #(
  parameter int WAIT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_down,
  input  logic [WAIT_W-1:0] wait_cnt,
  output logic              bias_ready
);
  logic [WAIT_W-1:0] cnt_q;
  logic [WAIT_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || pwr_down) begin
      cnt_q      <= '0;
      bias_ready <= 1'b0;
    end else if (!bias_ready) begin
      if (cnt_inc >= {1'b0, wait_cnt}) bias_ready <= 1'b1;
      else                             cnt_q      <= cnt_inc[WAIT_W-1:0];
    end
  end
endmodule

// File: rtl/clklane_dur_timer.sv
module clklane_dur_timer #(
  parameter int DUR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DUR_W-1:0] load_val,
  output logic             done
);
  logic [DUR_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                         cnt_q <= '0;
    else if (load)                   cnt_q <= load_val;
    else if (cnt_q > DUR_W'(1))      cnt_q <= cnt_q - 1'b1;
  end

  // value n gives n cycles in the phase, 0 gives one
  assign done = (cnt_q <= DUR_W'(1));
endmodule

// File: rtl/dsi_clklane_seq.sv
module dsi_clklane_seq
  import clklane_pkg::*;
#(
  parameter int DUR_W   = 8,
  parameter int PWRUP_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pwr_down_i,
  input  logic               hs_req_i,
  input  logic               data_idle_i,
  input  logic [4*DUR_W-1:0] clk_tim_i,
  input  logic [4*DUR_W-1:0] clk_pre_tim_i,
  input  logic [PWRUP_W-1:0] pwrup_wait_i,
  output logic               tx_lp_en_o,
  output logic               tx_hs_en_o,
  output logic               data_ready_o,
  output logic [3:0]         lane_state_o
);
  localparam int PREP_LSB  = 3 * DUR_W;
  localparam int ZERO_LSB  = 2 * DUR_W;
  localparam int POST_LSB  = DUR_W;
  localparam int TRAIL_LSB = 0;

  logic [DUR_W-1:0] f_prep, f_zero, f_post, f_trail, f_pre;
  assign f_prep  = clk_tim_i[PREP_LSB  +: DUR_W];
  assign f_zero  = clk_tim_i[ZERO_LSB  +: DUR_W];
  assign f_post  = clk_tim_i[POST_LSB  +: DUR_W];
  assign f_trail = clk_tim_i[TRAIL_LSB +: DUR_W];
  assign f_pre   = clk_pre_tim_i[DUR_W-1:0];

  logic bias_ready;
  clklane_bias_timer #(.WAIT_W(PWRUP_W)) u_bias (
    .clk        (clk),
    .rst        (rst),
    .pwr_down   (pwr_down_i),
    .wait_cnt   (pwrup_wait_i),
    .bias_ready (bias_ready)
  );

  logic             ld;
  logic [DUR_W-1:0] ld_val;
  logic             dur_done;
  clklane_dur_timer #(.DUR_W(DUR_W)) u_dur (
    .clk      (clk),
    .rst      (rst),
    .load     (ld),
    .load_val (ld_val),
    .done     (dur_done)
  );

  phase_e ph_q, ph_n;

  always_comb begin
    ph_n   = ph_q;
    ld     = 1'b0;
    ld_val = '0;
    if (pwr_down_i) begin
      ph_n = PH_OFF;
    end else begin
      case (ph_q)
        PH_OFF:   if (bias_ready) ph_n = PH_STOP;
        PH_STOP:  if (hs_req_i) begin ph_n = PH_PREP; ld = 1'b1; ld_val = f_prep; end
        PH_PREP:  if (dur_done) begin ph_n = PH_ZERO; ld = 1'b1; ld_val = f_zero; end
        PH_ZERO:  if (dur_done) begin ph_n = PH_PRE;  ld = 1'b1; ld_val = f_pre;  end
        PH_PRE:   if (dur_done) ph_n = PH_HS;
        PH_HS:    if (!hs_req_i && data_idle_i) begin
                    ph_n = PH_POST; ld = 1'b1; ld_val = f_post;
                  end
        PH_POST:  if (dur_done) begin ph_n = PH_TRAIL; ld = 1'b1; ld_val = f_trail; end
        PH_TRAIL: if (dur_done) ph_n = PH_STOP;
        default:  ph_n = PH_OFF;
      endcase
    end
  end

  lane_out_t out_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= PH_OFF;
      out_q <= phase_outs(PH_OFF);
    end else begin
      ph_q  <= ph_n;
      out_q <= phase_outs(ph_n);
    end
  end

  assign tx_lp_en_o   = out_q.lp_en;
  assign tx_hs_en_o   = out_q.hs_en;
  assign data_ready_o = out_q.ready;
  assign lane_state_o = {bias_ready, out_q.stop, 1'b0, out_q.hs_act};
endmodule

// File: rtl/dsi_clklane_seq_chk.sv
module dsi_clklane_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       pwr_down_i,
  input logic       hs_req_i,
  input logic       data_idle_i,
  input logic       tx_lp_en_o,
  input logic       tx_hs_en_o,
  input logic       data_ready_o,
  input logic [3:0] lane_state_o
);
  AST_PD_QUIET: assert property (@(posedge clk) disable iff (rst)
    pwr_down_i |=> (!tx_lp_en_o && !tx_hs_en_o && !data_ready_o && !lane_state_o[3])); // R10

  AST_LP_HS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(tx_lp_en_o && tx_hs_en_o)); // R3

  AST_LP_NEEDS_BIAS: assert property (@(posedge clk) disable iff (rst)
    tx_lp_en_o |-> lane_state_o[3]); // R2

  AST_READY_DRIVES_HS: assert property (@(posedge clk) disable iff (rst)
    data_ready_o |-> (tx_hs_en_o && lane_state_o[0])); // R6

  AST_READY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (data_ready_o && hs_req_i && !pwr_down_i) |=> data_ready_o); // R6

  AST_HS_START_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_hs_en_o) |-> (!data_ready_o && !lane_state_o[0])); // R5

  AST_EXIT_NEEDS_IDLE: assert property (@(posedge clk) disable iff (rst)
    ($fell(data_ready_o) && !$past(pwr_down_i)) |-> ($past(data_idle_i) && !$past(hs_req_i))); // R7
endmodule

bind dsi_clklane_seq dsi_clklane_seq_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .pwr_down_i   (pwr_down_i),
  .hs_req_i     (hs_req_i),
  .data_idle_i  (data_idle_i),
  .tx_lp_en_o   (tx_lp_en_o),
  .tx_hs_en_o   (tx_hs_en_o),
  .data_ready_o (data_ready_o),
  .lane_state_o (lane_state_o)
);

// File: tb/dsi_clklane_seq_bench.sv
module dsi_clklane_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DUR_W      = 8;
  localparam int PWRUP_W    = 16;
  localparam int LIMIT      = 400;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               pwr_down = 1'b1;
  logic               hs_req = 1'b0;
  logic               data_idle = 1'b1;
  logic [4*DUR_W-1:0] tim = '0;
  logic [4*DUR_W-1:0] pre_tim = '0;
  logic [PWRUP_W-1:0] pwrup_wait = '0;
  logic               lp_en, hs_en, ready;
  logic [3:0]         st;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsi_clklane_seq #(.DUR_W(DUR_W), .PWRUP_W(PWRUP_W)) u_dsi_clklane_seq (
    .clk           (clk),
    .rst           (rst),
    .pwr_down_i    (pwr_down),
    .hs_req_i      (hs_req),
    .data_idle_i   (data_idle),
    .clk_tim_i     (tim),
    .clk_pre_tim_i (pre_tim),
    .pwrup_wait_i  (pwrup_wait),
    .tx_lp_en_o    (lp_en),
    .tx_hs_en_o    (hs_en),
    .data_ready_o  (ready),
    .lane_state_o  (st)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int mx1(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic bit is_stop();  return lp_en && !hs_en && st == 4'b1100; endfunction
  function automatic bit is_prep();  return !lp_en && !hs_en && st[3]; endfunction
  function automatic bit is_hsnr();  return hs_en && !ready && !st[0]; endfunction
  function automatic bit is_post();  return hs_en && !ready && st[0]; endfunction

  task automatic wait_stop();
    for (int i = 0; i < LIMIT && !is_stop(); i++) @(negedge clk);
  endtask

  // one full HS cycle; drop: release during prepare; idle_dly: cycles data_idle held low;
  // rereq: raise request again during post
  task automatic run_cycle(input string tag, input int p, input int z, input int pr,
                           input int po, input int t, input int hold,
                           input bit drop, input int idle_dly, input bit rereq);
    int n;
    wait_stop();
    tim     = {p[7:0], z[7:0], po[7:0], t[7:0]};
    pre_tim = {24'hFFFFFF, pr[7:0]};
    hs_req  = 1'b1;
    @(negedge clk);
    if (drop) hs_req = 1'b0;
    n = 0;
    while (is_prep() && n < LIMIT) begin n++; @(negedge clk); end
    check({tag, " R4 prepare cycles"}, n, mx1(p));
    n = 0;
    while (is_hsnr() && n < LIMIT) begin n++; @(negedge clk); end
    check({tag, " R5 zero+pre cycles"}, n, mx1(z) + mx1(pr));
    check({tag, " R6 ready with hs"}, int'(ready && hs_en && st[0]), 1);
    if (drop) begin
      n = 0;
      while (ready && n < LIMIT) begin n++; @(negedge clk); end
      check({tag, " R9 single ready cycle"}, n, 1);
    end else begin
      for (int i = 1; i < hold; i++) begin
        @(negedge clk);
        check({tag, " R6 ready held by request"}, int'(ready), 1);
      end
      hs_req    = 1'b0;
      data_idle = (idle_dly == 0);
      for (int i = 0; i < idle_dly; i++) begin
        @(negedge clk);
        check({tag, " R6 ready held while data busy"}, int'(ready), 1);
      end
      data_idle = 1'b1;
      @(negedge clk);
    end
    if (rereq) hs_req = 1'b1;
    n = 0;
    while (is_post() && n < LIMIT) begin n++; @(negedge clk); end
    check({tag, " R7 post cycles"}, n, mx1(po));
    n = 0;
    while (is_hsnr() && n < LIMIT) begin n++; @(negedge clk); end
    check({tag, " R8 trail cycles"}, n, mx1(t));
    check({tag, " R8 back to stop"}, int'(is_stop()), 1);
    if (rereq) begin
      @(negedge clk);
      check({tag, " R11 re-entry after one stop cycle"}, int'(is_prep()), 1);
      hs_req = 1'b0;
      wait_stop();
    end
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {lp_en, hs_en, ready, st}, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 power-down outputs", {lp_en, hs_en, ready, st}, 0);
  endtask

  task automatic test_powerup(input int w);
    int n;
    pwrup_wait = w[PWRUP_W-1:0];
    pwr_down   = 1'b0;
    n = 0;
    @(negedge clk);
    n = 1;
    while (!st[3] && n < LIMIT) begin n++; @(negedge clk); end
    check("R2 bias ready edge count", n, mx1(w));
    check("R2 still powered down at bias ready", int'(lp_en || st[2]), 0);
    @(negedge clk);
    check("R3 stop state outputs", {lp_en, hs_en, ready, st}, {3'b100, 4'b1100});
  endtask

  task automatic test_pd_in_hs();
    wait_stop();
    tim    = 32'h02020202;
    hs_req = 1'b1;
    for (int i = 0; i < LIMIT && !ready; i++) @(negedge clk);
    pwr_down = 1'b1;
    @(negedge clk);
    check("R10 power-down from HS", {lp_en, hs_en, ready, st}, 0);
    hs_req = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 hold power-down", {lp_en, hs_en, ready, st}, 0);
    test_powerup(3);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    test_reset();
    test_powerup(5);
    run_cycle("distinct", 3, 5, 2, 4, 6, 3, 1'b0, 0, 1'b0);
    run_cycle("allzero",  0, 0, 0, 0, 0, 1, 1'b0, 0, 1'b0);
    run_cycle("longpre",  1, 2, 9, 1, 2, 2, 1'b0, 0, 1'b0);
    run_cycle("early_drop", 4, 3, 2, 2, 3, 1, 1'b1, 0, 1'b0);
    run_cycle("idle_wait",  2, 2, 2, 3, 2, 2, 1'b0, 5, 1'b0);
    run_cycle("rereq",      2, 1, 1, 5, 4, 2, 1'b0, 0, 1'b1);
    test_pd_in_hs();
    run_cycle("after_pd",   1, 1, 1, 1, 1, 1, 1'b0, 0, 1'b0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule